// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block is one programmable macrocell of a complex PLD logic block. A sum-of-products term arrives from the logic array. It passes through an inverting XOR and then feeds a single storage element. A static configuration word sets that element up as an edge-triggered D register, a level-sensitive flow-through latch or a toggle flip-flop. The same word chooses the clock, the clock enable, the reset and the preset from small pools of global, local and product-term sources. Each of these four controls has its own polarity bit.

The macrocell has two outputs: one feeds the local array and one drives routing. Each output selects on its own between the stored value and the plain combinational value, so the two can carry unrelated functions. The macrocell runs on a fast system clock `clk` that samples the selected clock source. An active clock edge is detected as a 0-to-1 change of the selected and polarity-adjusted source level between two consecutive `clk` samples.

Top module: `pld_macrocell`

## Requirements
- R1: The combinational value is `sop_i` XOR `cfg_i[0]`. It appears on any output set to combinational in the same cycle, with no register in the path.
- R2: `cfg_i[17]`=1 routes the stored value to `fb_o` and 0 routes the combinational value. `cfg_i[18]` does the same for `route_o`. The two choices are independent.
- R3: In D mode (`cfg_i[2:1]` = 0, with code 3 behaving the same), an enabled active clock edge sampled at a `clk` rising edge loads the combinational value. The new value appears on a stored-value output in the next cycle.
- R4: In latch mode (`cfg_i[2:1]` = 1), while the clock level is 1 and the enable is active, the stored-value output follows the combinational value in the same cycle. When the latch closes, it holds the last value it passed.
- R5: In toggle mode (`cfg_i[2:1]` = 2), an enabled active clock edge inverts the stored value when the combinational value is 1 and leaves it unchanged when it is 0.
- R6: `cfg_i[5:3]` selects the clock: 0-3 are global clocks 0-3, 4-5 are local clocks 0-1, 6 is the product-term clock and 7 is constant 0. `cfg_i[6]`=1 inverts the source, which makes the falling edge active and the latch transparent while the source is low. Edges on sources that are not selected have no effect.
- R7: `cfg_i[9:7]` selects the clock enable: 0-1 are global, 2-3 are local, 4 is the product term, 5 is constant 1 and 6-7 are constant 0. `cfg_i[10]`=1 makes it active low. While the enable is inactive, clock edges leave the stored value unchanged.
- R8: `cfg_i[12:11]` selects the reset: 0-1 are global set/reset lines, 2 is the product-term reset and 3 is constant 0. `cfg_i[13]`=1 inverts it. An active reset forces the stored-value output to 0 in the same cycle and keeps the stored value at 0.
- R9: `cfg_i[15:14]` selects the preset from the same pool, with the product-term preset at code 2. `cfg_i[16]`=1 inverts it. An active preset forces the stored-value output to 1 in the same cycle and loads 1.
- R10: When reset and preset are active together, the stored-value output is 0.
- R11: While `rst_n` is low, the stored value is 0. The first `clk` sample after release never counts as a clock edge, even when the selected clock is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| sop_i | input | 1 | Sum-of-products term from the logic array |
| gclk_i | input | 4 | Global clock sources |
| lclk_i | input | 2 | Local clock sources |
| pt_clk_i | input | 1 | Product-term clock |
| gce_i | input | 2 | Global clock-enable sources |
| lce_i | input | 2 | Local clock-enable sources |
| pt_ce_i | input | 1 | Product-term clock enable |
| gsr_i | input | 2 | Global set/reset lines |
| pt_rst_i | input | 1 | Product-term reset |
| pt_prs_i | input | 1 | Product-term preset |
| cfg_i | input | 19 | Static configuration word (fields in R1-R9 order of bits) |
| fb_o | output | 1 | Output to the local array |
| route_o | output | 1 | Output to routing |

## Verification
The riskiest overlap comes in a single cycle that holds an enabled active clock edge together with an active reset or preset, or with both at once. The storage priority then has to pick reset over preset over the mode's load. The directed part drives reset and preset together while the selected clock rises, with the stored value at 1 beforehand. The random part draws sources and configurations so that edges and overrides coincide often. A bench model, stepped once per sample, predicts both outputs in every cycle, and each output is compared against that prediction.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  parameter int N_GCLK = 4;
  parameter int N_LCLK = 2;
  parameter int N_GCE  = 2;
  parameter int N_LCE  = 2;
  parameter int N_GSR  = 2;

  // source pools include one constant entry each
  localparam int CLK_SRCS  = N_GCLK + N_LCLK + 2;
  localparam int CE_SRCS   = N_GCE + N_LCE + 2;
  localparam int SR_SRCS   = N_GSR + 2;
  localparam int CLK_SEL_W = $clog2(CLK_SRCS);
  localparam int CE_SEL_W  = $clog2(CE_SRCS);
  localparam int SR_SEL_W  = $clog2(SR_SRCS);

  typedef enum logic [1:0] {
    ST_DFF   = 2'd0,
    ST_LATCH = 2'd1,
    ST_TFF   = 2'd2,
    ST_DFF2  = 2'd3
  } store_mode_e;

  // declared MSB first: inv ends at bit 0
  typedef struct packed {
    logic                 rt_reg;
    logic                 fb_reg;
    logic                 prs_pol;
    logic [SR_SEL_W-1:0]  prs_sel;
    logic                 rst_pol;
    logic [SR_SEL_W-1:0]  rst_sel;
    logic                 ce_pol;
    logic [CE_SEL_W-1:0]  ce_sel;
    logic                 clk_pol;
    logic [CLK_SEL_W-1:0] clk_sel;
    store_mode_e          mode;
    logic                 inv;
  } mc_cfg_t;

  localparam int CFG_W = $bits(mc_cfg_t);

  function automatic logic post_xor(logic sop, logic inv);
    return sop ^ inv;
  endfunction

  function automatic logic mode_load(store_mode_e m, logic fire, logic open_lvl, logic d);
    case (m)
      ST_LATCH: return open_lvl;
      ST_TFF:   return fire & d;
      default:  return fire;
    endcase
  endfunction

  function automatic logic mode_next(store_mode_e m, logic st, logic d);
    return (m == ST_TFF) ? ~st : d;
  endfunction

  function automatic logic pick_out(logic use_reg, logic reg_v, logic comb_v);
    return use_reg ? reg_v : comb_v;
  endfunction

endpackage

// File: rtl/pmc_src_pick.sv
module pmc_src_pick #(
  parameter int N_SRC = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inv_i,
  output logic             lvl_o
);

  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_i == SEL_W'(i)) picked = src_i[i];
    end
    lvl_o = picked ^ inv_i;
  end

endmodule

// File: rtl/pmc_edge_detect.sv
module pmc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic edge_o
);

  logic prev_q;
  logic primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      primed_q <= 1'b1;
    end
  end

  assign edge_o = primed_q & lvl_i & ~prev_q;

  // R6: an edge lasts one sample and needs a low sample before it
  a_r6_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
  a_r6_edge_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (lvl_i && !$past(lvl_i)));

endmodule

// File: rtl/pmc_storage.sv
module pmc_storage
  import pmc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  store_mode_e mode_i,
  input  logic        d_i,
  input  logic        edge_i,
  input  logic        lvl_i,
  input  logic        ce_i,
  input  logic        rst_i,
  input  logic        prs_i,
  output logic        q_o
);

  logic state_q;
  logic fire;
  logic open_lvl;
  logic load;
  logic nxt;
  logic ovr;

  assign fire     = edge_i & ce_i;
  assign open_lvl = lvl_i & ce_i;
  assign load     = mode_load(mode_i, fire, open_lvl, d_i);
  assign nxt      = mode_next(mode_i, state_q, d_i);
  assign ovr      = rst_i | prs_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= 1'b0;
    else if (rst_i)   state_q <= 1'b0;
    else if (prs_i)   state_q <= 1'b1;
    else if (load)    state_q <= nxt;
  end

  always_comb begin
    if (rst_i)                                  q_o = 1'b0;
    else if (prs_i)                             q_o = 1'b1;
    else if (mode_i == ST_LATCH && open_lvl)    q_o = d_i;
    else                                        q_o = state_q;
  end

  // R3: D capture
  a_r3_dff_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == ST_DFF || mode_i == ST_DFF2) && fire && !ovr) |=> (state_q == $past(d_i)));
  // R4: closed latch holds
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == ST_LATCH && !open_lvl && !ovr) |=> $stable(state_q));
  // R5: toggle behaviour
  a_r5_tff_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == ST_TFF && fire && d_i && !ovr) |=> (state_q != $past(state_q)));
  a_r5_tff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == ST_TFF && !d_i && !ovr) |=> $stable(state_q));
  // R7: disabled enable blocks updates
  a_r7_ce_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_i && !ovr) |=> $stable(state_q));
  // R8 / R9: overrides reach the stored value
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_i |=> !state_q);
  a_r9_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (prs_i && !rst_i) |=> state_q);

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_i,
  input  logic [N_GCLK-1:0] gclk_i,
  input  logic [N_LCLK-1:0] lclk_i,
  input  logic              pt_clk_i,
  input  logic [N_GCE-1:0]  gce_i,
  input  logic [N_LCE-1:0]  lce_i,
  input  logic              pt_ce_i,
  input  logic [N_GSR-1:0]  gsr_i,
  input  logic              pt_rst_i,
  input  logic              pt_prs_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              fb_o,
  output logic              route_o
);

  mc_cfg_t cfg;
  assign cfg = mc_cfg_t'(cfg_i);

  logic comb_v;
  logic clk_lvl;
  logic ce_act;
  logic clk_edge;
  logic reg_v;
  logic [1:0] ovr_act;   // [0] reset, [1] preset

  assign comb_v = post_xor(sop_i, cfg.inv);

  pmc_src_pick #(.N_SRC(CLK_SRCS), .SEL_W(CLK_SEL_W)) u_clk_pick (
    .src_i ({1'b0, pt_clk_i, lclk_i, gclk_i}),
    .sel_i (cfg.clk_sel),
    .inv_i (cfg.clk_pol),
    .lvl_o (clk_lvl)
  );

  pmc_src_pick #(.N_SRC(CE_SRCS), .SEL_W(CE_SEL_W)) u_ce_pick (
    .src_i ({1'b1, pt_ce_i, lce_i, gce_i}),
    .sel_i (cfg.ce_sel),
    .inv_i (cfg.ce_pol),
    .lvl_o (ce_act)
  );

  generate
    for (genvar k = 0; k < 2; k++) begin : g_ovr
      logic [SR_SEL_W-1:0] sel_k;
      logic                pol_k;
      logic                pt_k;
      assign sel_k = (k == 0) ? cfg.rst_sel : cfg.prs_sel;
      assign pol_k = (k == 0) ? cfg.rst_pol : cfg.prs_pol;
      assign pt_k  = (k == 0) ? pt_rst_i    : pt_prs_i;
      pmc_src_pick #(.N_SRC(SR_SRCS), .SEL_W(SR_SEL_W)) u_sr_pick (
        .src_i ({1'b0, pt_k, gsr_i}),
        .sel_i (sel_k),
        .inv_i (pol_k),
        .lvl_o (ovr_act[k])
      );
    end
  endgenerate

  pmc_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (clk_lvl),
    .edge_o (clk_edge)
  );

  pmc_storage u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (cfg.mode),
    .d_i    (comb_v),
    .edge_i (clk_edge),
    .lvl_i  (clk_lvl),
    .ce_i   (ce_act),
    .rst_i  (ovr_act[0]),
    .prs_i  (ovr_act[1]),
    .q_o    (reg_v)
  );

  assign fb_o    = pick_out(cfg.fb_reg, reg_v, comb_v);
  assign route_o = pick_out(cfg.rt_reg, reg_v, comb_v);

  // R1: combinational outputs track the inverted sum term
  a_r1_comb_route: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.rt_reg |-> (route_o == (sop_i ^ cfg.inv)));
  // R2: each output chooses on its own
  a_r2_split_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.fb_reg && cfg.rt_reg) |-> (fb_o == (sop_i ^ cfg.inv)));
  // R10: reset beats preset at the port
  a_r10_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_act[0] && ovr_act[1] && cfg.fb_reg) |-> !fb_o);

endmodule

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic sop;
  logic [3:0] g_clk;
  logic [1:0] l_clk;
  logic p_clk;
  logic [1:0] g_ce, l_ce;
  logic p_ce;
  logic [1:0] g_sr;
  logic p_rst, p_prs;
  logic [18:0] cfg;
  logic fb_o, route_o;

  int n_chk = 0;
  int n_err = 0;
  string phase = "";
  bit m_state = 0, m_prev = 0, m_primed = 0;

  always #2.5 clk = ~clk;

  pld_macrocell u_dut (
    .clk(clk), .rst_n(rst_n), .sop_i(sop), .gclk_i(g_clk), .lclk_i(l_clk),
    .pt_clk_i(p_clk), .gce_i(g_ce), .lce_i(l_ce), .pt_ce_i(p_ce), .gsr_i(g_sr),
    .pt_rst_i(p_rst), .pt_prs_i(p_prs), .cfg_i(cfg), .fb_o(fb_o), .route_o(route_o)
  );

  function automatic logic [18:0] mk_cfg(bit inv, bit [1:0] mode, bit [2:0] cs, bit cp,
      bit [2:0] es, bit ep, bit [1:0] rs, bit rp, bit [1:0] ps, bit pp, bit fr, bit rr);
    return {rr, fr, pp, ps, rp, rs, ep, es, cp, cs, mode, inv};
  endfunction

  function automatic bit m_clk();
    bit v;
    case (cfg[5:3])
      3'd0, 3'd1, 3'd2, 3'd3: v = g_clk[cfg[4:3]];
      3'd4, 3'd5: v = l_clk[cfg[3]];
      3'd6: v = p_clk;
      default: v = 1'b0;
    endcase
    return v ^ cfg[6];
  endfunction

  function automatic bit m_ce();
    bit v;
    case (cfg[9:7])
      3'd0, 3'd1: v = g_ce[cfg[7]];
      3'd2, 3'd3: v = l_ce[cfg[7]];
      3'd4: v = p_ce;
      3'd5: v = 1'b1;
      default: v = 1'b0;
    endcase
    return v ^ cfg[10];
  endfunction

  function automatic bit m_sr(bit [1:0] s, bit pol, bit pt);
    bit v;
    case (s)
      2'd0, 2'd1: v = g_sr[s[0]];
      2'd2: v = pt;
      default: v = 1'b0;
    endcase
    return v ^ pol;
  endfunction

  function automatic bit m_rst(); return m_sr(cfg[12:11], cfg[13], p_rst); endfunction
  function automatic bit m_prs(); return m_sr(cfg[15:14], cfg[16], p_prs); endfunction
  function automatic bit m_d();   return sop ^ cfg[0]; endfunction

  function automatic bit m_reg();
    if (m_rst()) return 1'b0;
    if (m_prs()) return 1'b1;
    if (cfg[2:1] == 2'd1 && m_clk() && m_ce()) return m_d();
    return m_state;
  endfunction

  function automatic string tag_for(bit use_reg);
    if (phase != "") return phase;
    if (!use_reg) return "R1";
    if (m_rst() && m_prs()) return "R10";
    if (m_rst()) return "R8";
    if (m_prs()) return "R9";
    if (cfg[2:1] == 2'd1) return "R4";
    if (cfg[2:1] == 2'd2) return "R5";
    return "R3";
  endfunction

  task automatic check(string tag, logic act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit lvl, e, ce;
    if (!rst_n) begin
      m_state = 0; m_prev = 0; m_primed = 0;
      return;
    end
    lvl = m_clk(); ce = m_ce();
    e = m_primed && lvl && !m_prev;
    if (m_rst()) m_state = 0;
    else if (m_prs()) m_state = 1;
    else case (cfg[2:1])
      2'd1: if (lvl && ce) m_state = m_d();
      2'd2: if (e && ce && m_d()) m_state = !m_state;
      default: if (e && ce) m_state = m_d();
    endcase
    m_prev = lvl; m_primed = 1;
  endtask

  task automatic run_cycle();
    bit rv;
    #1;
    rv = m_reg();
    check(tag_for(cfg[17]), fb_o,    cfg[17] ? rv : m_d());
    check(tag_for(cfg[18]), route_o, cfg[18] ? rv : m_d());
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic tick_g0(int n);
    for (int i = 0; i < n; i++) begin
      g_clk[0] = ~g_clk[0];
      sop = ~sop ^ i[1];
      run_cycle();
    end
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 0; sop = 1; g_clk = 4'h1; l_clk = 0; p_clk = 0;
    g_ce = 0; l_ce = 0; p_ce = 0; g_sr = 0; p_rst = 0; p_prs = 0;
    cfg = mk_cfg(0, 2'd0, 3'd0, 0, 3'd5, 0, 2'd3, 0, 2'd3, 0, 1, 1);
    @(negedge clk);

    // R11: reset state, and no edge on the first sample after release
    phase = "R11";
    run_cycle(); run_cycle();
    rst_n = 1;
    run_cycle(); run_cycle();

    // R3: global clock 0, D mode
    phase = "R3";
    tick_g0(8);
    cfg[2:1] = 2'd3; tick_g0(4);

    // R1: inverted combinational path on both outputs
    phase = "R1";
    cfg = mk_cfg(1, 2'd0, 3'd0, 0, 3'd5, 0, 2'd3, 0, 2'd3, 0, 0, 0);
    sop = 0; run_cycle(); sop = 1; run_cycle();

    // R2: feedback stored, routing combinational and the reverse
    phase = "R2";
    cfg[17] = 1; tick_g0(4);
    cfg[17] = 0; cfg[18] = 1; tick_g0(4);

    // R6: local clock 1, falling edge active, global clock toggles unselected
    phase = "R6";
    cfg = mk_cfg(0, 2'd0, 3'd5, 1, 3'd5, 0, 2'd3, 0, 2'd3, 0, 1, 1);
    for (int i = 0; i < 8; i++) begin
      l_clk[1] = i[0]; g_clk[0] = ~g_clk[0]; sop = i[1]; run_cycle();
    end

    // R7: product-term enable, active low
    phase = "R7";
    cfg = mk_cfg(0, 2'd0, 3'd0, 0, 3'd4, 1, 2'd3, 0, 2'd3, 0, 1, 1);
    p_ce = 1; tick_g0(6);
    p_ce = 0; tick_g0(6);

    // R4: latch open, then closed
    phase = "R4";
    cfg = mk_cfg(0, 2'd1, 3'd6, 0, 3'd5, 0, 2'd3, 0, 2'd3, 0, 1, 0);
    p_clk = 1;
    for (int i = 0; i < 4; i++) begin sop = i[0]; run_cycle(); end
    p_clk = 0;
    for (int i = 0; i < 4; i++) begin sop = ~i[0]; run_cycle(); end

    // R5: toggle with data 1, then hold with data 0
    phase = "R5";
    cfg = mk_cfg(0, 2'd2, 3'd0, 0, 3'd5, 0, 2'd3, 0, 2'd3, 0, 1, 1);
    for (int i = 0; i < 8; i++) begin g_clk[0] = ~g_clk[0]; sop = 1; run_cycle(); end
    for (int i = 0; i < 6; i++) begin g_clk[0] = ~g_clk[0]; sop = 0; run_cycle(); end

    // R9: global set/reset line 1, active low, forces 1
    phase = "R9";
    cfg = mk_cfg(0, 2'd0, 3'd0, 0, 3'd5, 0, 2'd3, 0, 2'd1, 1, 1, 1);
    g_sr = 2'b10; sop = 0; tick_g0(2);
    g_sr = 2'b00; tick_g0(3);

    // R10: reset and preset together during an edge
    phase = "R10";
    cfg = mk_cfg(0, 2'd0, 3'd0, 0, 3'd5, 0, 2'd2, 0, 2'd2, 0, 1, 1);
    p_prs = 1; p_rst = 1; sop = 1; g_clk[0] = 1; run_cycle(); run_cycle();

    // R8: product-term reset alone
    phase = "R8";
    p_prs = 0; run_cycle();
    p_prs = 1; p_rst = 0; run_cycle();
    p_prs = 0; p_rst = 1; g_clk[0] = 0; run_cycle(); g_clk[0] = 1; run_cycle();
    p_rst = 0;

    // random mix: tags chosen per cycle from the active function
    phase = "";
    for (int c = 0; c < 4000; c++) begin
      if (c % 40 == 0) begin
        cfg = 19'($urandom);
        if ($urandom % 2) begin cfg[12:11] = 2'd3; cfg[13] = 0; end
        if ($urandom % 2) begin cfg[15:14] = 2'd3; cfg[16] = 0; end
      end
      sop = 1'($urandom); g_clk = 4'($urandom); l_clk = 2'($urandom);
      p_clk = 1'($urandom); g_ce = 2'($urandom); l_ce = 2'($urandom);
      p_ce = 1'($urandom);
      g_sr = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      p_rst = ($urandom % 6 == 0); p_prs = ($urandom % 6 == 0);
      run_cycle();
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule